// File: doc/BRIEF.md
# Fuse-Array Controller with Write-Once Protection

This block fronts a one-time-programmable fuse array that holds `WORDS` 32-bit words. A full-size part uses 4096 words, or 16 KB. Software reaches it through a simple 32-bit register bus. Each request is one cycle long and carries a byte offset. The response comes back one cycle later with a valid flag, read data and an error pulse. Control registers hold the following values:

- the word index
- the bit position
- the data bit
- three read enables: chip, strobe and trim
- a redundancy select
- a clock register and a test register, which are stored but not acted on
- the program enable

A read of the data-out register returns the addressed fuse word only while all three read enables are on.

Programming works on one bit at a time. Writing a 1 to the program-enable register copies the data bit into the chosen bit of the addressed word. A shadow flag for that bit records the write. A later program of the same bit is refused and raises a sticky violation output. A nonzero redundancy select blocks programming entirely.

Reset fills every word with ones and clears every written flag. It then seeds a serial number at a fixed word index and the serial number's complement at the next index.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Every request is a 32-bit access at a word-aligned byte offset. The offsets are:
  - 0x00: word index
  - 0x04: bit position
  - 0x08: data bit
  - 0x0C: program enable
  - 0x10: chip enable
  - 0x14: strobe enable
  - 0x18: trim enable
  - 0x1C: data out
  - 0x20: redundancy select
  - 0x24: clock
  - 0x28: test

  `rsp_valid` is high exactly one cycle after each cycle with `req_valid` high, and low otherwise.
- R2: An access to any other offset, including any offset with `req_addr[1:0]` nonzero, behaves as follows: it returns `rsp_rdata` = 0, pulses `rsp_err` for that one response cycle, and changes no register.
- R3: The following registers read back the last value written to them: bit position, data bit, chip, strobe, trim, redundancy, clock and test. The word-index register stores only bits [log2(WORDS)-1:0] of the written value; all upper bits read as 0. A write response carries `rsp_rdata` = 0.
- R4: A data-out read returns the addressed word only when bit 0 of chip enable, bit 0 of strobe enable and bit 0 of trim enable are all 1. Otherwise it returns 0x000000FF.
- R5: A write to data out changes nothing. The fuse word read afterwards is unchanged.
- R6: A program-enable write stores only bit 0 of the written value, so it reads back as 0 or 1. If that bit is 1 and redundancy select is 0, bit `bitpos[4:0]` of word `index` takes the value of data-bit register bit 0. The result is visible to a data-out read from the next request on.
- R7: While redundancy select is nonzero, a program request alters neither the fuse word nor the bit's written flag. The bit can still be programmed later.
- R8: A program request for a bit whose written flag is set leaves the word unchanged. The request also sets `wo_violation`, which then stays high until reset.
- R9: After reset, the following all hold: every fuse word is all ones except the serial words, every written flag is clear, every register reads 0, and `wo_violation`, `rsp_valid` and `rsp_err` are low.
- R10: After reset, word `SERIAL_IDX` holds `SERIAL_NUM` and word `SERIAL_IDX+1` holds `~SERIAL_NUM`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | One-cycle pulse for an unmapped or misaligned offset |
| wo_violation | output | 1 | Sticky flag: a written bit was programmed again |

## Verification
Programming is tried with several sequences, each telling a different behaviour apart:

- Clearing a bit shows that the write took effect.
- Reprogramming that bit to 1 separates refusal from a plain overwrite.
- Programming while redundancy select is nonzero, then again with it zero, shows that a suppressed request leaves the written flag clear.
- Writing 0xFFFFFFFE to program enable shows that only bit 0 of the value counts.

Data-out reads are made with each enable missing in turn, so a design that gates on fewer than three enables is caught. Reads of the two seeded words and a re-program after a second reset separate the reset contents from state left over from before.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

    localparam logic [31:0] BLOCKED_READ = 32'h0000_00FF;

    // Register selector; the value equals the word offset (byte offset / 4)
    typedef enum logic [3:0] {
        SEL_INDEX  = 4'd0,
        SEL_BITPOS = 4'd1,
        SEL_DBIT   = 4'd2,
        SEL_PGM    = 4'd3,
        SEL_CHIP   = 4'd4,
        SEL_STROBE = 4'd5,
        SEL_TRIM   = 4'd6,
        SEL_DOUT   = 4'd7,
        SEL_SPARE  = 4'd8,
        SEL_CLK    = 4'd9,
        SEL_TEST   = 4'd10,
        SEL_NONE   = 4'd15
    } reg_sel_e;

    typedef struct packed {
        logic [31:0] index;
        logic [31:0] bitpos;
        logic [31:0] dbit;
        logic [31:0] chip;
        logic [31:0] strobe;
        logic [31:0] trim;
        logic [31:0] spare;
        logic [31:0] clk_reg;
        logic [31:0] test;
        logic        pgm;
    } ctrl_t;

    function automatic reg_sel_e decode_off(logic [7:0] off);
        if (off[1:0] != 2'b00 || off[7:6] != 2'b00 || off[5:2] > 4'd10)
            return SEL_NONE;
        return reg_sel_e'(off[5:2]);
    endfunction

    function automatic logic [31:0] init_word(int unsigned w, int unsigned sidx,
                                              logic [31:0] sn);
        if (w == sidx)     return sn;
        if (w == sidx + 1) return ~sn;
        return '1;
    endfunction

endpackage

// File: rtl/otp_fuse_regs.sv
module otp_fuse_regs
    import otp_fuse_pkg::*;
#(
    parameter int unsigned WORDS = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  reg_sel_e    sel,
    input  logic [31:0] wdata,
    output ctrl_t       ctrl,
    output logic        pgm_req
);
    localparam logic [31:0] IDX_MASK = 32'(WORDS - 1);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_INDEX:  ctrl_q.index   <= wdata & IDX_MASK;
                SEL_BITPOS: ctrl_q.bitpos  <= wdata;
                SEL_DBIT:   ctrl_q.dbit    <= wdata;
                SEL_PGM:    ctrl_q.pgm     <= wdata[0];
                SEL_CHIP:   ctrl_q.chip    <= wdata;
                SEL_STROBE: ctrl_q.strobe  <= wdata;
                SEL_TRIM:   ctrl_q.trim    <= wdata;
                SEL_SPARE:  ctrl_q.spare   <= wdata;
                SEL_CLK:    ctrl_q.clk_reg <= wdata;
                SEL_TEST:   ctrl_q.test    <= wdata;
                default:    ;  // data out is read-only
            endcase
        end
    end

    assign ctrl    = ctrl_q;
    assign pgm_req = wr_en && (sel == SEL_PGM) && wdata[0] && (ctrl_q.spare == '0);

endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store
    import otp_fuse_pkg::*;
#(
    parameter int unsigned WORDS      = 128,
    parameter int unsigned SERIAL_IDX = 120,
    parameter logic [31:0] SERIAL_NUM = 32'h1234_5678,
    localparam int unsigned AW        = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pgm_req,
    input  logic [AW-1:0] idx,
    input  logic [4:0]    bit_pos,
    input  logic          bit_val,
    output logic [31:0]   rd_word,
    output logic          reject
);
    logic [31:0] mem_q  [WORDS];
    logic [31:0] flag_q [WORDS];

    logic already;
    assign already = flag_q[idx][bit_pos];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(WORDS); i++) begin
                mem_q[i]  <= init_word(i, SERIAL_IDX, SERIAL_NUM);
                flag_q[i] <= '0;
            end
        end else if (pgm_req && !already) begin
            mem_q[idx][bit_pos]  <= bit_val;
            flag_q[idx][bit_pos] <= 1'b1;
        end
    end

    assign rd_word = mem_q[idx];
    assign reject  = pgm_req && already;

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_fuse_pkg::*;
#(
    parameter int unsigned WORDS      = 128,
    parameter int unsigned SERIAL_IDX = 120,
    parameter logic [31:0] SERIAL_NUM = 32'h1234_5678
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err,
    output logic        wo_violation
);
    localparam int unsigned AW = $clog2(WORDS);

    reg_sel_e    sel;
    ctrl_t       ctrl_q;
    logic        pgm_req;
    logic        reject;
    logic [31:0] rd_word;
    logic [31:0] rd_mux;
    logic        wr_en;

    assign sel   = decode_off(req_addr);
    assign wr_en = req_valid && req_write && (sel != SEL_NONE);

    otp_fuse_regs #(.WORDS(WORDS)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .sel     (sel),
        .wdata   (req_wdata),
        .ctrl    (ctrl_q),
        .pgm_req (pgm_req)
    );

    otp_fuse_store #(
        .WORDS      (WORDS),
        .SERIAL_IDX (SERIAL_IDX),
        .SERIAL_NUM (SERIAL_NUM)
    ) i_store (
        .clk     (clk),
        .rst     (rst),
        .pgm_req (pgm_req),
        .idx     (ctrl_q.index[AW-1:0]),
        .bit_pos (ctrl_q.bitpos[4:0]),
        .bit_val (ctrl_q.dbit[0]),
        .rd_word (rd_word),
        .reject  (reject)
    );

    always_comb begin
        unique case (sel)
            SEL_INDEX:  rd_mux = ctrl_q.index;
            SEL_BITPOS: rd_mux = ctrl_q.bitpos;
            SEL_DBIT:   rd_mux = ctrl_q.dbit;
            SEL_PGM:    rd_mux = {31'b0, ctrl_q.pgm};
            SEL_CHIP:   rd_mux = ctrl_q.chip;
            SEL_STROBE: rd_mux = ctrl_q.strobe;
            SEL_TRIM:   rd_mux = ctrl_q.trim;
            SEL_DOUT:   rd_mux = (ctrl_q.chip[0] && ctrl_q.strobe[0] && ctrl_q.trim[0])
                                 ? rd_word : BLOCKED_READ;
            SEL_SPARE:  rd_mux = ctrl_q.spare;
            SEL_CLK:    rd_mux = ctrl_q.clk_reg;
            SEL_TEST:   rd_mux = ctrl_q.test;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            rsp_err      <= 1'b0;
            wo_violation <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_err      <= req_valid && (sel == SEL_NONE);
            rsp_rdata    <= (req_valid && !req_write) ? rd_mux : '0;
            wo_violation <= wo_violation || reject;
        end
    end

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_err,
    input logic        wo_violation,
    input logic        reject,
    input logic [31:0] rd_word,
    input logic        chip_on,
    input logic        strobe_on,
    input logic        trim_on
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);  // R1
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);  // R1
    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));  // R2
    AST_BLOCKED_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == 8'h1C && !(chip_on && strobe_on && trim_on))
        |=> rsp_rdata == 32'h0000_00FF);  // R4
    AST_REJECT_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst)
        reject |=> $stable(rd_word));  // R8
    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        reject |=> wo_violation);  // R8
    AST_VIOLATION_STICKY: assert property (@(posedge clk) disable iff (rst)
        wo_violation |=> wo_violation);  // R8
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .rsp_err      (rsp_err),
    .wo_violation (wo_violation),
    .reject       (reject),
    .rd_word      (rd_word),
    .chip_on      (ctrl_q.chip[0]),
    .strobe_on    (ctrl_q.strobe[0]),
    .trim_on      (ctrl_q.trim[0])
);

// File: tb/test_otp_fuse_ctrl.sv
module test_otp_fuse_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        wo_violation;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    otp_fuse_ctrl i_otp_fuse_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .rsp_err      (rsp_err),
        .wo_violation (wo_violation)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  off;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        err;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h1C, 32'h0,          32'h0000_00FF, 1'b0, 4'd4},  // R4 enables off
        '{1'b1, 8'h00, 32'hFFFF_FF05,  32'h0,         1'b0, 4'd3},
        '{1'b0, 8'h00, 32'h0,          32'h0000_0005, 1'b0, 4'd3},  // R3 index masked
        '{1'b1, 8'h10, 32'h1,          32'h0,         1'b0, 4'd4},
        '{1'b1, 8'h14, 32'h1,          32'h0,         1'b0, 4'd4},
        '{1'b0, 8'h1C, 32'h0,          32'h0000_00FF, 1'b0, 4'd4},  // R4 trim off
        '{1'b1, 8'h18, 32'h1,          32'h0,         1'b0, 4'd4},
        '{1'b0, 8'h1C, 32'h0,          32'hFFFF_FFFF, 1'b0, 4'd9},  // R9 blank word
        '{1'b1, 8'h04, 32'h3,          32'h0,         1'b0, 4'd6},
        '{1'b1, 8'h08, 32'h0,          32'h0,         1'b0, 4'd6},
        '{1'b1, 8'h0C, 32'h1,          32'h0,         1'b0, 4'd6},  // R6 program bit 3 to 0
        '{1'b0, 8'h1C, 32'h0,          32'hFFFF_FFF7, 1'b0, 4'd6},
        '{1'b0, 8'h0C, 32'h0,          32'h0000_0001, 1'b0, 4'd6},
        '{1'b1, 8'h0C, 32'hFFFF_FFFE,  32'h0,         1'b0, 4'd6},  // R6 bit0 only
        '{1'b0, 8'h0C, 32'h0,          32'h0000_0000, 1'b0, 4'd6},
        '{1'b1, 8'h08, 32'h1,          32'h0,         1'b0, 4'd8},
        '{1'b1, 8'h0C, 32'h1,          32'h0,         1'b0, 4'd8},  // R8 second program
        '{1'b0, 8'h1C, 32'h0,          32'hFFFF_FFF7, 1'b0, 4'd8},
        '{1'b1, 8'h04, 32'h5,          32'h0,         1'b0, 4'd7},
        '{1'b1, 8'h20, 32'h2,          32'h0,         1'b0, 4'd7},
        '{1'b1, 8'h08, 32'h0,          32'h0,         1'b0, 4'd7},
        '{1'b1, 8'h0C, 32'h1,          32'h0,         1'b0, 4'd7},  // R7 suppressed
        '{1'b0, 8'h1C, 32'h0,          32'hFFFF_FFF7, 1'b0, 4'd7},
        '{1'b0, 8'h20, 32'h0,          32'h0000_0002, 1'b0, 4'd3},
        '{1'b1, 8'h20, 32'h0,          32'h0,         1'b0, 4'd7},
        '{1'b1, 8'h0C, 32'h1,          32'h0,         1'b0, 4'd7},  // R7 flag still clear
        '{1'b0, 8'h1C, 32'h0,          32'hFFFF_FFD7, 1'b0, 4'd7},
        '{1'b1, 8'h1C, 32'h0,          32'h0,         1'b0, 4'd5},  // R5 write to dout
        '{1'b0, 8'h1C, 32'h0,          32'hFFFF_FFD7, 1'b0, 4'd5},
        '{1'b1, 8'h24, 32'h0000_A5A5,  32'h0,         1'b0, 4'd3},
        '{1'b0, 8'h24, 32'h0,          32'h0000_A5A5, 1'b0, 4'd3},
        '{1'b1, 8'h28, 32'h0000_003C,  32'h0,         1'b0, 4'd3},
        '{1'b0, 8'h28, 32'h0,          32'h0000_003C, 1'b0, 4'd3},
        '{1'b0, 8'h2C, 32'h0,          32'h0,         1'b1, 4'd2},  // R2 unmapped
        '{1'b0, 8'h02, 32'h0,          32'h0,         1'b1, 4'd2},  // R2 misaligned
        '{1'b1, 8'h40, 32'h7,          32'h0,         1'b1, 4'd2},
        '{1'b1, 8'h01, 32'h11,         32'h0,         1'b1, 4'd2},
        '{1'b0, 8'h00, 32'h0,          32'h0000_0005, 1'b0, 4'd2},  // R2 no change
        '{1'b1, 8'h00, 32'd120,        32'h0,         1'b0, 4'd10},
        '{1'b0, 8'h1C, 32'h0,          32'h1234_5678, 1'b0, 4'd10}, // R10 serial
        '{1'b1, 8'h00, 32'd121,        32'h0,         1'b0, 4'd10},
        '{1'b0, 8'h1C, 32'h0,          32'hEDCB_A987, 1'b0, 4'd10}, // R10 complement
        '{1'b1, 8'h00, 32'h0000_0087,  32'h0,         1'b0, 4'd3},
        '{1'b0, 8'h00, 32'h0,          32'h0000_0007, 1'b0, 4'd3},
        '{1'b1, 8'h10, 32'h0,          32'h0,         1'b0, 4'd4},
        '{1'b0, 8'h1C, 32'h0,          32'h0000_00FF, 1'b0, 4'd4}   // R4 chip off
    };

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] off, input logic [31:0] wd,
                          output logic [31:0] rd, output logic err, output logic vld);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = off;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        rd  = rsp_rdata;
        err = rsp_err;
        vld = rsp_valid;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        err;
        logic        vld;

        do_reset();
        // R9: reset state of outputs
        check("R9", {61'b0, rsp_valid, rsp_err, wo_violation}, 64'h0);
        // R1: no response without request
        @(negedge clk);
        check("R1", {63'b0, rsp_valid}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].off, VECS[i].wd, rd, err, vld);
            check($sformatf("R%0d vec%0d", VECS[i].rq, i),
                  {30'b0, vld, err, rd}, {30'b0, 1'b1, VECS[i].err, VECS[i].exp});
        end

        // R1: response strobe lasts one cycle only
        @(negedge clk);
        check("R1", {63'b0, rsp_valid}, 64'h0);
        // R8: sticky violation raised by the refused program
        check("R8", {63'b0, wo_violation}, 64'h1);

        do_reset();
        // R9: violation cleared, registers zeroed
        check("R9", {63'b0, wo_violation}, 64'h0);
        access(1'b0, 8'h04, 32'h0, rd, err, vld);
        check("R9", {32'b0, rd}, 64'h0);
        access(1'b0, 8'h24, 32'h0, rd, err, vld);
        check("R9", {32'b0, rd}, 64'h0);

        // R9: word 5 is blank again and bit 3 programmable once more
        access(1'b1, 8'h00, 32'd5, rd, err, vld);
        access(1'b1, 8'h10, 32'h1, rd, err, vld);
        access(1'b1, 8'h14, 32'h1, rd, err, vld);
        access(1'b1, 8'h18, 32'h1, rd, err, vld);
        access(1'b0, 8'h1C, 32'h0, rd, err, vld);
        check("R9", {32'b0, rd}, 64'hFFFF_FFFF);
        access(1'b1, 8'h04, 32'h3, rd, err, vld);
        access(1'b1, 8'h0C, 32'h1, rd, err, vld);  // data bit is 0 after reset
        access(1'b0, 8'h1C, 32'h0, rd, err, vld);
        check("R9", {32'b0, rd}, 64'hFFFF_FFF7);
        check("R8", {63'b0, wo_violation}, 64'h0);

        // R4: strobe enable alone off blocks the read
        access(1'b1, 8'h14, 32'h2, rd, err, vld);
        access(1'b0, 8'h1C, 32'h0, rd, err, vld);
        check("R4", {32'b0, rd}, 64'h0000_00FF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule